// File: doc/BRIEF.md
# RSI Mean-Reversion Decision Core

This block watches a stream of unsigned Q16.16 prices, one per `price_valid` pulse, and for every accepted price produces a trading action together with the current Relative Strength Index. Each accepted price is compared with the one before it. The change goes into a gain channel when the price rose and into a loss channel when it fell. Both channels are smoothed over a lookback of `PERIOD` changes. The first averages are plain means. After that the block applies Wilder's recursive smoothing.

The index is formed as `10000 * avgGain / (avgGain + avgLoss)` by a restoring divider that settles one quotient bit per clock. The result is a value from 0 to 10000, where 10000 means 100.00. A value below the oversold threshold yields a buy code. A value above the overbought threshold yields a sell code. Anything else, the thresholds themselves included, yields hold.

While a price is being processed the block raises `busy` and ignores further prices. Until enough history exists it answers with a neutral, not-ready result.

Top module: `rsi_decider`

## Requirements
- R1: A price is accepted on a rising edge where `price_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle onward. `res_valid` is a single-cycle pulse that follows the 18th rising edge, counting the accepting edge as the first, and `busy` is 0 in that cycle.
- R2: A `price_valid` pulse that arrives while `busy` is 1 has no effect on any later result.
- R3: For the first `PERIOD` prices after reset, each result carries `ready`=0, `rsi`=5000 and action HOLD.
- R4: Prices are compared as unsigned 32-bit values, so 0x80000000 is above 0x7FFF0000. A rise adds to gain and a fall adds to loss. When the (`PERIOD`+1)th price arrives, each average becomes floor(sum of the first `PERIOD` changes / `PERIOD`).
- R5: Every later price updates each average to floor((avg*(`PERIOD`-1) + change) / `PERIOD`).
- R6: Once ready, `rsi` = floor(10000*avgGain/(avgGain+avgLoss)). When both averages are 0, `rsi` is 5000. `rsi` never exceeds 10000.
- R7: `action` is BUY, code 1, when `rsi` is below 3000.
- R8: `action` is SELL, code 2, when `rsi` is above 7000.
- R9: `action` is HOLD, code 0, when `rsi` lies in 3000..7000 inclusive. Code 3 never appears.
- R10: A synchronous reset clears the history and both averages. After reset `busy`, `res_valid` and `ready` are 0, `rsi` is 5000 and `action` is 0, and warm-up (R3) starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| price_valid | input | 1 | Strobe marking a new price |
| price | input | PRICE_W (32) | Unsigned Q16.16 price |
| busy | output | 1 | Computation in progress; new prices are ignored |
| res_valid | output | 1 | One-cycle pulse marking a fresh result |
| action | output | 2 | 0 hold, 1 buy, 2 sell |
| rsi | output | 14 | Index in hundredths, 0 to 10000 |
| ready | output | 1 | History is complete and `rsi` is a true index |

## Verification
The bench builds the core with `PERIOD` set to 5 and the default 32-bit price width. The short lookback makes the end of warm-up, the seeding of the averages and several rounds of Wilder smoothing reachable within a few dozen prices. Hand-picked changes of 15, 35 and 0 units land the index exactly on 3000 and 7000 and then just off them, which exercises both threshold edges. The full 32-bit width lets the bench walk prices across the 0x80000000 boundary to test the unsigned comparison.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
   localparam int RSI_W    = 14;
   localparam int RSI_FULL = 10000;
   localparam int RSI_MID  = 5000;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_BUY  = 2'd1,
      ACT_SELL = 2'd2
   } action_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AVG,
      ST_LOAD,
      ST_DIV,
      ST_OUT
   } state_e;
endpackage

// File: rtl/rsi_delta.sv
// Splits the move between two prices into a gain and a loss magnitude.
module rsi_delta #(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic         valid_prev,
   output logic [W-1:0] gain,
   output logic [W-1:0] loss
);
   always_comb begin
      gain = '0;
      loss = '0;
      if (valid_prev) begin
         if (cur > prev) gain = cur - prev;
         else            loss = prev - cur;
      end
   end
endmodule

// File: rtl/rsi_smoother.sv
// One averaging channel: simple mean during seeding, Wilder recursion after.
module rsi_smoother #(
   parameter int W      = 32,
   parameter int PERIOD = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         seeded,
   input  logic         seed_last,
   input  logic [W-1:0] sample,
   output logic [W-1:0] avg
);
   localparam int SW = W + $clog2(PERIOD + 1);

   logic [SW-1:0] sum_q;
   logic [SW-1:0] acc;
   logic [W-1:0]  quo;

   always_comb begin
      if (seeded) acc = SW'(avg) * SW'(PERIOD - 1) + SW'(sample);
      else        acc = sum_q + SW'(sample);
      quo = W'(acc / SW'(PERIOD));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= '0;
         avg   <= '0;
      end else if (step) begin
         if (!seeded)              sum_q <= acc;
         if (seeded || seed_last)  avg   <= quo;
      end
   end
endmodule

// File: rtl/rsi_divider.sv
// Restoring divider, one quotient bit per cycle, MSB first.
// Requires num < den * 2**Q_W so that the quotient fits in Q_W bits.
module rsi_divider #(
   parameter int NUM_W = 46,
   parameter int DEN_W = 33,
   parameter int Q_W   = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             last,
   output logic [Q_W-1:0]   quot
);
   localparam int RW = DEN_W + Q_W;
   localparam int CW = $clog2(Q_W);

   if (NUM_W > RW) begin : g_bad_width
      $error("rsi_divider: numerator wider than remainder");
   end
   if (Q_W < 2) begin : g_bad_q
      $error("rsi_divider: quotient needs at least two bits");
   end

   logic [RW-1:0] rem_q;
   logic [RW-1:0] dsh_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          fits;

   assign fits = rem_q >= dsh_q;
   assign last = run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q <= '0;
         dsh_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         quot  <= '0;
      end else if (start) begin
         rem_q <= RW'(num);
         dsh_q <= RW'(den) << (Q_W - 1);
         cnt_q <= CW'(Q_W - 1);
         run_q <= 1'b1;
         quot  <= '0;
      end else if (run_q) begin
         if (fits) rem_q <= rem_q - dsh_q;
         quot  <= {quot[Q_W-2:0], fits};
         dsh_q <= dsh_q >> 1;
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/rsi_decider.sv
module rsi_decider
   import rsi_pkg::*;
#(
   parameter int PRICE_W = 32,
   parameter int PERIOD  = 14,
   parameter int BUY_TH  = 3000,
   parameter int SELL_TH = 7000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               price_valid,
   input  logic [PRICE_W-1:0] price,
   output logic               busy,
   output logic               res_valid,
   output logic [1:0]         action,
   output logic [RSI_W-1:0]   rsi,
   output logic               ready
);
   localparam int CNT_W = $clog2(PERIOD + 1);
   localparam int NUM_W = PRICE_W + RSI_W;
   localparam int DEN_W = PRICE_W + 1;
   localparam logic [RSI_W-1:0] BUY_L  = RSI_W'(BUY_TH);
   localparam logic [RSI_W-1:0] SELL_L = RSI_W'(SELL_TH);
   localparam logic [RSI_W-1:0] MID_L  = RSI_W'(RSI_MID);

   if (PERIOD < 2) begin : g_bad_period
      $error("rsi_decider: PERIOD must be at least 2");
   end
   if (BUY_TH >= SELL_TH || SELL_TH > RSI_FULL) begin : g_bad_thresh
      $error("rsi_decider: thresholds out of order or range");
   end
   if (PRICE_W < 2) begin : g_bad_price
      $error("rsi_decider: PRICE_W too small");
   end

   state_e             state_q;
   logic [PRICE_W-1:0] prev_q, gain_q, loss_q, d_gain, d_loss;
   logic               have_prev_q, chg_q;
   logic [CNT_W-1:0]   nchg_q;
   logic               warm, seed_last, avg_step;
   logic [PRICE_W-1:0] ch_sample [2];
   logic [PRICE_W-1:0] ch_avg    [2];
   logic [NUM_W-1:0]   div_num;
   logic [DEN_W-1:0]   div_den;
   logic               div_last;
   logic [RSI_W-1:0]   div_quot, rsi_n, rsi_q;
   action_e            act_n, act_q;
   logic               valid_q, ready_q;

   rsi_delta #(.W(PRICE_W)) u_delta (
      .cur(price), .prev(prev_q), .valid_prev(have_prev_q),
      .gain(d_gain), .loss(d_loss)
   );

   assign warm      = nchg_q == CNT_W'(PERIOD);
   assign seed_last = nchg_q == CNT_W'(PERIOD - 1);
   assign avg_step  = (state_q == ST_AVG) && chg_q;
   assign ch_sample[0] = gain_q;
   assign ch_sample[1] = loss_q;

   // Channel 0 tracks gains, channel 1 tracks losses.
   for (genvar c = 0; c < 2; c++) begin : g_chan
      rsi_smoother #(.W(PRICE_W), .PERIOD(PERIOD)) u_smooth (
         .clk(clk), .rst(rst), .step(avg_step), .seeded(warm),
         .seed_last(seed_last), .sample(ch_sample[c]), .avg(ch_avg[c])
      );
   end

   assign div_num = NUM_W'(ch_avg[0]) * NUM_W'(RSI_FULL);
   assign div_den = DEN_W'(ch_avg[0]) + DEN_W'(ch_avg[1]);

   rsi_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(RSI_W)) u_div (
      .clk(clk), .rst(rst), .start(state_q == ST_LOAD),
      .num(div_num), .den(div_den), .last(div_last), .quot(div_quot)
   );

   always_comb begin
      rsi_n = (!warm || div_den == '0) ? MID_L : div_quot;
      if (rsi_n < BUY_L)       act_n = ACT_BUY;
      else if (rsi_n > SELL_L) act_n = ACT_SELL;
      else                     act_n = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         prev_q      <= '0;
         have_prev_q <= 1'b0;
         gain_q      <= '0;
         loss_q      <= '0;
         chg_q       <= 1'b0;
         nchg_q      <= '0;
         valid_q     <= 1'b0;
         ready_q     <= 1'b0;
         rsi_q       <= MID_L;
         act_q       <= ACT_HOLD;
      end else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (price_valid) begin
               prev_q      <= price;
               have_prev_q <= 1'b1;
               gain_q      <= d_gain;
               loss_q      <= d_loss;
               chg_q       <= have_prev_q;
               state_q     <= ST_AVG;
            end
            ST_AVG: begin
               if (chg_q && !warm) nchg_q <= nchg_q + CNT_W'(1);
               state_q <= ST_LOAD;
            end
            ST_LOAD: state_q <= ST_DIV;
            ST_DIV:  if (div_last) state_q <= ST_OUT;
            ST_OUT: begin
               valid_q <= 1'b1;
               ready_q <= warm;
               rsi_q   <= rsi_n;
               act_q   <= act_n;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = state_q != ST_IDLE;
   assign res_valid = valid_q;
   assign ready     = ready_q;
   assign rsi       = rsi_q;
   assign action    = act_q;
endmodule

// File: rtl/rsi_decider_chk.sv
module rsi_decider_chk
   import rsi_pkg::*;
#(
   parameter int BUY_TH  = 3000,
   parameter int SELL_TH = 7000
) (
   input logic             clk,
   input logic             rst,
   input logic             price_valid,
   input logic             busy,
   input logic             res_valid,
   input logic [1:0]       action,
   input logic [RSI_W-1:0] rsi,
   input logic             ready
);
   localparam logic [RSI_W-1:0] BUY_L  = RSI_W'(BUY_TH);
   localparam logic [RSI_W-1:0] SELL_L = RSI_W'(SELL_TH);
   localparam logic [RSI_W-1:0] MID_L  = RSI_W'(RSI_MID);
   localparam logic [RSI_W-1:0] FULL_L = RSI_W'(RSI_FULL);

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
      price_valid && !busy |=> busy); // R1
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid); // R1
   AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !busy && $past(busy)); // R1
   AST_WARM_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
      res_valid && !ready |-> rsi == MID_L && action == 2'd0); // R3
   AST_RSI_RANGE: assert property (@(posedge clk) disable iff (rst)
      rsi <= FULL_L); // R6
   AST_BUY_BAND: assert property (@(posedge clk) disable iff (rst)
      res_valid && action == 2'd1 |-> rsi < BUY_L); // R7
   AST_SELL_BAND: assert property (@(posedge clk) disable iff (rst)
      res_valid && action == 2'd2 |-> rsi > SELL_L); // R8
   AST_HOLD_BAND: assert property (@(posedge clk) disable iff (rst)
      res_valid && action == 2'd0 |-> rsi >= BUY_L && rsi <= SELL_L); // R9
   AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
      action != 2'd3); // R9
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !busy && !res_valid && !ready && rsi == MID_L); // R10
endmodule

bind rsi_decider rsi_decider_chk #(.BUY_TH(BUY_TH), .SELL_TH(SELL_TH)) u_chk (
   .clk(clk), .rst(rst), .price_valid(price_valid), .busy(busy),
   .res_valid(res_valid), .action(action), .rsi(rsi), .ready(ready)
);

// File: tb/tb_rsi_decider.sv
module tb_rsi_decider;
   localparam int P = 5;
   localparam int U = 65536;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        price_valid = 1'b0;
   logic [31:0] price = '0;
   logic        busy, res_valid, ready;
   logic [1:0]  action;
   logic [13:0] rsi;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   bit started = 0;

   rsi_decider #(.PRICE_W(32), .PERIOD(P)) dut (
      .clk(clk), .rst(rst), .price_valid(price_valid), .price(price),
      .busy(busy), .res_valid(res_valid), .action(action), .rsi(rsi),
      .ready(ready)
   );

   always #5 clk = ~clk;

   // ---------------- behavioural reference ----------------
   int             mcnt;
   bit             mhave, ev, erdy, prdy;
   longint unsigned mprev, sg, sl, ag, al, ersi, prsi;
   int             mn, eact, pact;

   task automatic model_accept(input longint unsigned p);
      longint unsigned g, l, d;
      if (!mhave) begin
         mhave = 1; mprev = p;
      end else begin
         g = 0; l = 0;
         if (p > mprev) g = p - mprev; else l = mprev - p;
         mprev = p;
         if (mn < P) begin
            sg += g; sl += l; mn++;
            if (mn == P) begin ag = sg / P; al = sl / P; end
         end else begin
            ag = (ag * (P - 1) + g) / P;
            al = (al * (P - 1) + l) / P;
         end
      end
      prdy = (mn == P);
      if (!prdy) prsi = 5000;
      else begin
         d = ag + al;
         prsi = (d == 0) ? 5000 : (10000 * ag) / d;
      end
      pact = (prsi < 3000) ? 1 : (prsi > 7000) ? 2 : 0;
   endtask

   always @(posedge clk) begin
      started = 1;
      cyc++;
      if (rst) begin
         mcnt = 0; mhave = 0; mprev = 0; mn = 0; sg = 0; sl = 0;
         ag = 0; al = 0; ev = 0; erdy = 0; ersi = 5000; eact = 0;
      end else begin
         ev = 0;
         if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin ev = 1; ersi = prsi; erdy = prdy; eact = pact; end
         end else if (price_valid) begin
            model_accept(longint'(price));
            mcnt = 17;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint a, input longint e);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk(busy == (mcnt > 0), "R1 busy", busy, (mcnt > 0));
         chk(res_valid == ev, "R1 res_valid", res_valid, ev);
         chk(ready == erdy, "R3 ready", ready, erdy);
         chk(rsi == ersi, "R6 rsi", rsi, ersi);
         chk(action == eact, "R9 action", action, eact);
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   always @(posedge clk) begin
      if (cyc == 150000) begin
         nchk++; nerr++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
         report();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   int          last_rsi, last_act;
   bit          last_rdy;

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic feed(input logic [31:0] p, input bit poke);
      int k;
      @(negedge clk);
      while (busy) @(negedge clk);
      price = p; price_valid = 1'b1;
      @(negedge clk);
      price_valid = 1'b0;
      k = 1;
      while (!res_valid) begin
         if (poke && k == 5) begin
            chk(busy == 1'b1, "R2 busy during poke", busy, 1);
            price = 32'hFFFF_0000; price_valid = 1'b1;
         end else begin
            price_valid = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      price_valid = 1'b0;
      chk(k == 18, "R1 latency", k, 18);
      last_rsi = rsi; last_act = action; last_rdy = ready;
   endtask

   task automatic expect_res(input string tag, input int r, input int a, input bit rd);
      chk(last_rsi == r, tag, last_rsi, r);
      chk(last_act == a, tag, last_act, a);
      chk(last_rdy == rd, tag, last_rdy, rd);
   endtask

   initial begin
      int unsigned lcg;
      do_reset();
      chk(busy == 0 && res_valid == 0 && ready == 0, "R10 reset flags", {busy, res_valid, ready}, 0);
      chk(rsi == 5000 && action == 0, "R10 reset rsi", rsi, 5000);

      // steady rise: warm-up then saturated index
      for (int i = 0; i < 6; i++) begin
         feed(32'((100 + i) * U), 1'b0);
         if (i < P) expect_res("R3 warm-up neutral", 5000, 0, 0);
      end
      expect_res("R8 rise gives sell", 10000, 2, 1);
      feed(32'(106 * U), 1'b0);
      expect_res("R5 wilder keeps 10000", 10000, 2, 1);

      // exact 3000 then one below
      do_reset();
      feed(32'(100 * U), 1'b0); feed(32'(115 * U), 1'b0); feed(32'(80 * U), 1'b0);
      expect_res("R10 history restarted", 5000, 0, 0);
      for (int i = 0; i < 3; i++) feed(32'(80 * U), 1'b0);
      expect_res("R9 exactly 3000 holds (R4 seed)", 3000, 0, 1);
      feed(32'(80 * U), 1'b0);
      expect_res("R7 2999 buys (R5 smoothing)", 2999, 1, 1);

      // exact 7000 twice
      do_reset();
      feed(32'(100 * U), 1'b0); feed(32'(135 * U), 1'b0); feed(32'(120 * U), 1'b0);
      for (int i = 0; i < 3; i++) feed(32'(120 * U), 1'b0);
      expect_res("R9 exactly 7000 holds", 7000, 0, 1);
      feed(32'(120 * U), 1'b0);
      expect_res("R5 smoothed 7000 holds", 7000, 0, 1);

      // flat prices with ignored pokes
      do_reset();
      for (int i = 0; i < 6; i++) feed(32'(50 * U), (i == 2 || i == 5));
      expect_res("R2 pokes ignored, R6 zero averages", 5000, 0, 1);

      // steady fall
      do_reset();
      for (int i = 0; i < 6; i++) feed(32'((200 - i) * U), 1'b0);
      expect_res("R7 fall gives buy", 0, 1, 1);

      // unsigned crossing of the top bit
      do_reset();
      for (int i = 0; i < 6; i++) feed(32'h7FFF_0000 + 32'(i * U), 1'b0);
      expect_res("R4 unsigned rise across MSB", 10000, 2, 1);

      // pseudo-random walk, compared to the model every cycle
      lcg = 32'd12345;
      for (int i = 0; i < 30; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         feed(32'(100 * U) + ((lcg >> 8) % 32'(20 * U)), (i % 7 == 3));
      end

      repeat (3) @(negedge clk);
      report();
      $finish;
   end
endmodule